// File: doc/BRIEF.md
# Paged GPIO Edge-Interrupt Controller

This block is a 48-line general-purpose I/O peripheral with a byte-wide register bus. The lines form six 8-bit ports. Each data register has two roles. It holds the value driven onto the line, and it sets the line's direction: a 1 drives the line and a 0 releases it. Reading a data port returns the level at the pads after a two-stage synchronizer. The pad side is open-drain style: a drive-enable vector goes out, and a separate input vector comes in.

Only the lowest three ports (lines 0 to 23) can interrupt. Each of these lines has a polarity bit, an enable bit and a latched pending bit. The three registers for a port share one address in a three-byte window. A page register picks which bank that window shows, so software selects the page first and then touches the bank. An enabled line whose selected edge arrives sets its pending bit. The single interrupt output stays high while any pending bit is set. Software clears pending bits by writing ones to the identification bank.

Top module: `gpio_paged_edge_irq`

## Requirements
- R1: A write to offset p (0 to 5) stores the byte in data port p. From the next clock, bit n of that byte appears on `pad_drive[8p+n]` (1 = drive, 0 = released). All data ports are 0 after reset.
- R2: A read of offset p (0 to 5) returns `pad_in[8p+7:8p]` as it stood before the second-to-last rising clock edge. A change is not visible after only one edge.
- R3: Offset 7 holds a 2-bit page field in bits 7:6. A read returns the field in bits 7:6 and zeros elsewhere. Page value 1 maps the polarity bank onto offsets 8, 9 and 10 (ports 0, 1, 2), value 2 maps the enable bank, and value 3 maps the pending (identification) bank.
- R4: After reset the page, all polarity bits, all enable bits and all pending bits are 0, and `irq` is low.
- R5: When a line's polarity bit is 1, a rising edge sets its pending bit. When the bit is 0, a falling edge sets it. If `pad_in` changes just before clock edge k, the pending bit is set by edge k+2.
- R6: A line whose enable bit is 0 never sets its pending bit. Enabling it later does not bring back an edge that arrived while it was masked.
- R7: With page 3 selected, writing a byte to offset 8+i clears each pending bit of port i whose data bit is 1. Bits written as 0 stay unchanged.
- R8: If a pending bit's edge and its clear land on the same clock edge, the bit ends up set.
- R9: `irq` is high exactly when at least one pending bit is set, and it stays high until every pending bit has been cleared.
- R10: Lines 24 to 47 have no interrupt logic. Their edges never raise `irq`.
- R11: Offset 6 reads as 0, and writes to it change nothing.
- R12: With page 0, offsets 8 to 10 read 0 and writes to them change nothing. Offsets 11 to 15 read 0. `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one access per clock |
| bus_rd | input | 1 | Read strobe; qualifies `bus_rdata` |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pad_in | input | 48 | Sampled pad levels |
| pad_drive | output | 48 | Per-line drive enable |
| irq | output | 1 | OR of all pending bits |

## Verification
The assertions assume a single strobe per cycle: a write aims at exactly one offset, and reset is held low for at least one clock edge before it is released. The falling-interrupt check also assumes that pending bits only drop through a clear written to the identification bank. The stimulus changes bus signals and pad levels only on falling clock edges and never issues two accesses in the same cycle. It holds the pads still during reset, so no edge can be inferred from values that existed before reset ended.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

   typedef enum logic [1:0] {
      BANK_NONE = 2'd0,
      BANK_POL  = 2'd1,
      BANK_ENA  = 2'd2,
      BANK_PEND = 2'd3
   } bank_sel_e;

   localparam int unsigned PAGE_FIELD_LSB = 6;
   localparam int unsigned PAGE_FIELD_W   = 2;

endpackage

// File: rtl/gpio_line_sync.sv
module gpio_line_sync #(
   parameter int unsigned WIDTH  = 48,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_line_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_line_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= '0;
            else        stage_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_out_port.sv
module gpio_out_port #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] drive_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_out_port: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] drive_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     drive_q <= '0;
      else if (wr_en) drive_q <= wr_data;
   end

   assign drive_o = drive_q;

   assert_port_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (drive_o == $past(wr_data)));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl_i,
   input  logic             pol_we,
   input  logic             ena_we,
   input  logic             ack_we,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] pol_o,
   output logic [WIDTH-1:0] ena_o,
   output logic [WIDTH-1:0] pend_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_irq_port: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] pol_q, ena_q, pend_q, prev_q;
   logic [WIDTH-1:0] rise, fall, hit, ack_mask;

   assign rise     = lvl_i & ~prev_q;
   assign fall     = ~lvl_i & prev_q;
   assign hit      = ((rise & pol_q) | (fall & ~pol_q)) & ena_q;
   assign ack_mask = ack_we ? wr_data : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q  <= '0;
         ena_q  <= '0;
         pend_q <= '0;
         prev_q <= '0;
      end else begin
         prev_q <= lvl_i;
         pend_q <= (pend_q & ~ack_mask) | hit;
         if (pol_we) pol_q <= wr_data;
         if (ena_we) ena_q <= wr_data;
      end
   end

   assign pol_o  = pol_q;
   assign ena_o  = ena_q;
   assign pend_o = pend_q;

   // R4: registers leave reset quiet
   assert_reset_quiet_R4: assert property (@(posedge clk)
      $rose(rst_n) |-> (pol_q == '0 && ena_q == '0 && pend_q == '0));

   // R6: a newly set pending bit needs its enable on the prior cycle
   assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q & ~$past(pend_q) & ~$past(ena_q)) == '0));

   assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ack_we |=> ((pend_q & $past(wr_data) & ~$past(hit)) == '0));

   assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> ((pend_q & $past(hit)) == $past(hit)));

endmodule

// File: rtl/gpio_paged_edge_irq.sv
module gpio_paged_edge_irq
   import gpio_edge_pkg::*;
#(
   parameter int unsigned PORTS       = 6,
   parameter int unsigned IRQ_PORTS   = 3,
   parameter int unsigned PORT_W      = 8,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [PORT_W-1:0]       bus_wdata,
   input  logic                    bus_wr,
   input  logic                    bus_rd,
   output logic [PORT_W-1:0]       bus_rdata,
   input  logic [PORTS*PORT_W-1:0] pad_in,
   output logic [PORTS*PORT_W-1:0] pad_drive,
   output logic                    irq
);

   localparam int unsigned NLINES   = PORTS * PORT_W;
   localparam int unsigned NIRQ     = IRQ_PORTS * PORT_W;
   localparam int unsigned RO_OFS   = PORTS;
   localparam int unsigned LOCK_OFS = PORTS + 1;
   localparam int unsigned BANK_OFS = PORTS + 2;

   if (IRQ_PORTS < 1 || IRQ_PORTS > PORTS) begin : g_bad_irq_ports
      $error("gpio_paged_edge_irq: IRQ_PORTS must lie in 1..PORTS");
   end
   if (BANK_OFS + IRQ_PORTS > (1 << ADDR_W)) begin : g_bad_addr_w
      $error("gpio_paged_edge_irq: ADDR_W too narrow for the register window");
   end
   if (PORT_W < PAGE_FIELD_LSB + PAGE_FIELD_W) begin : g_bad_port_w
      $error("gpio_paged_edge_irq: PORT_W too narrow for the page field");
   end

   // ---------------- input synchronizer ----------------
   logic [NLINES-1:0] lvl;

   gpio_line_sync #(
      .WIDTH  (NLINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pad_in),
      .q_o   (lvl)
   );

   // ---------------- page register ----------------
   bank_sel_e page_q;
   logic      page_we;

   assign page_we = bus_wr && (bus_addr == ADDR_W'(LOCK_OFS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       page_q <= BANK_NONE;
      else if (page_we) page_q <= bank_sel_e'(bus_wdata[PAGE_FIELD_LSB +: PAGE_FIELD_W]);
   end

   // ---------------- data ports ----------------
   for (genvar p = 0; p < PORTS; p++) begin : g_data
      logic we;
      assign we = bus_wr && (bus_addr == ADDR_W'(p));

      gpio_out_port #(
         .WIDTH (PORT_W)
      ) u_port (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (we),
         .wr_data (bus_wdata),
         .drive_o (pad_drive[p*PORT_W +: PORT_W])
      );
   end

   // ---------------- interrupt-capable ports ----------------
   logic [PORT_W-1:0] pol_v  [IRQ_PORTS];
   logic [PORT_W-1:0] ena_v  [IRQ_PORTS];
   logic [PORT_W-1:0] pend_v [IRQ_PORTS];
   logic [NIRQ-1:0]   pend_all;
   logic [NIRQ-1:0]   cfg_pol_all;
   logic [NIRQ-1:0]   cfg_ena_all;
   logic [IRQ_PORTS-1:0] bank_addr_hit;

   for (genvar i = 0; i < IRQ_PORTS; i++) begin : g_irq
      logic sel;
      assign sel              = bus_wr && (bus_addr == ADDR_W'(BANK_OFS + i));
      assign bank_addr_hit[i] = (bus_addr == ADDR_W'(BANK_OFS + i));

      gpio_irq_port #(
         .WIDTH (PORT_W)
      ) u_irq (
         .clk     (clk),
         .rst_n   (rst_n),
         .lvl_i   (lvl[i*PORT_W +: PORT_W]),
         .pol_we  (sel && (page_q == BANK_POL)),
         .ena_we  (sel && (page_q == BANK_ENA)),
         .ack_we  (sel && (page_q == BANK_PEND)),
         .wr_data (bus_wdata),
         .pol_o   (pol_v[i]),
         .ena_o   (ena_v[i]),
         .pend_o  (pend_v[i])
      );

      assign pend_all[i*PORT_W +: PORT_W]    = pend_v[i];
      assign cfg_pol_all[i*PORT_W +: PORT_W] = pol_v[i];
      assign cfg_ena_all[i*PORT_W +: PORT_W] = ena_v[i];
   end

   assign irq = |pend_all;

   // ---------------- read path ----------------
   logic [PORT_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      for (int p = 0; p < PORTS; p++) begin
         if (bus_addr == ADDR_W'(p)) rd_mux = lvl[p*PORT_W +: PORT_W];
      end
      if (bus_addr == ADDR_W'(LOCK_OFS)) begin
         rd_mux[PAGE_FIELD_LSB +: PAGE_FIELD_W] = page_q;
      end
      for (int i = 0; i < IRQ_PORTS; i++) begin
         if (bank_addr_hit[i]) begin
            case (page_q)
               BANK_POL:  rd_mux = pol_v[i];
               BANK_ENA:  rd_mux = ena_v[i];
               BANK_PEND: rd_mux = pend_v[i];
               default:   rd_mux = '0;
            endcase
         end
      end
   end

   assign bus_rdata = bus_rd ? rd_mux : '0;

   // ---------------- assertions ----------------
   assert_ro_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(RO_OFS)) |=> $stable(pad_drive));

   assert_page_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
      page_we |=> (2'(page_q) == $past(bus_wdata[PAGE_FIELD_LSB +: PAGE_FIELD_W])));

   assert_page_none_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && page_q == BANK_NONE && (|bank_addr_hit))
         |=> $stable({cfg_pol_all, cfg_ena_all}));

   assert_irq_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(bus_wr && page_q == BANK_PEND && (|bank_addr_hit)));

endmodule

// File: tb/tb_gpio_paged_edge_irq.sv
module tb_gpio_paged_edge_irq;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  bus_addr;
   logic [7:0]  bus_wdata;
   logic        bus_wr;
   logic        bus_rd;
   logic [7:0]  bus_rdata;
   logic [47:0] pad_in;
   logic [47:0] pad_drive;
   logic        irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_paged_edge_irq dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .pad_in    (pad_in),
      .pad_drive (pad_drive),
      .irq       (irq)
   );

   // ---------------- behavioural reference ----------------
   logic [47:0] m_data;
   logic [23:0] m_pol, m_en, m_pend, m_hit, m_clr;
   logic [1:0]  m_page;
   logic [47:0] m_s1, m_s2, m_prev;
   int          m_a;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_data = '0; m_pol = '0; m_en = '0; m_pend = '0; m_page = '0;
         m_s1 = '0; m_s2 = '0; m_prev = '0;
      end else begin
         m_a = int'(bus_addr);
         for (int i = 0; i < 24; i++) begin
            m_hit[i] = m_en[i] && (m_pol[i] ? (m_s2[i] && !m_prev[i])
                                            : (!m_s2[i] && m_prev[i]));
         end
         m_clr = '0;
         if (bus_wr && m_page == 2'd3 && m_a >= 8 && m_a <= 10)
            m_clr[(m_a-8)*8 +: 8] = bus_wdata;
         m_pend = (m_pend & ~m_clr) | m_hit;
         m_prev = m_s2;
         m_s2   = m_s1;
         m_s1   = pad_in;
         if (bus_wr) begin
            if (m_a <= 5) m_data[m_a*8 +: 8] = bus_wdata;
            else if (m_a == 7) m_page = bus_wdata[7:6];
            else if (m_a >= 8 && m_a <= 10) begin
               if (m_page == 2'd1) m_pol[(m_a-8)*8 +: 8] = bus_wdata;
               if (m_page == 2'd2) m_en[(m_a-8)*8 +: 8]  = bus_wdata;
            end
         end
      end
   end

   task automatic check(input bit ok, input string tag,
                        input logic [47:0] act, input logic [47:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done) begin
         check(pad_drive === m_data, "R1 pad_drive vs model", pad_drive, m_data);
         check(irq === (|m_pend), "R9 irq vs model", 48'(irq), 48'(|m_pend));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      check(bus_rdata === exp, tag, 48'(bus_rdata), 48'(exp));
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic set_pads(input logic [47:0] v);
      @(negedge clk);
      pad_in = v;
   endtask

   // ---------------- directed sequence ----------------
   initial begin
      rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
      pad_in = '0;
      idle(4);
      rst_n = 1'b1;

      // R4 reset state
      check(irq === 1'b0, "R4 irq after reset", 48'(irq), 48'h0);
      check(pad_drive === 48'h0, "R1 drive after reset", pad_drive, 48'h0);
      rd_chk(4'h7, 8'h00, "R4 page after reset");
      wr(4'h7, 8'h80);
      rd_chk(4'h8, 8'h00, "R4 enable port0 after reset");
      rd_chk(4'h9, 8'h00, "R4 enable port1 after reset");
      rd_chk(4'hA, 8'h00, "R4 enable port2 after reset");
      wr(4'h7, 8'h40);
      rd_chk(4'h8, 8'h00, "R4 polarity after reset");
      wr(4'h7, 8'hC0);
      rd_chk(4'h8, 8'h00, "R4 pending after reset");

      // R3 page field readback
      wr(4'h7, 8'hFF);
      rd_chk(4'h7, 8'hC0, "R3 page readback low bits zero");
      wr(4'h7, 8'h40);
      rd_chk(4'h7, 8'h40, "R3 page readback polarity");

      // R12 page 0 window and unmapped offsets
      wr(4'h7, 8'h00);
      rd_chk(4'h8, 8'h00, "R12 page0 window reads zero");
      wr(4'h8, 8'hFF);
      wr(4'h9, 8'hFF);
      rd_chk(4'hB, 8'h00, "R12 offset 0xB reads zero");
      rd_chk(4'hF, 8'h00, "R12 offset 0xF reads zero");
      wr(4'h7, 8'h80);
      rd_chk(4'h8, 8'h00, "R12 page0 write left enables");
      @(negedge clk);
      bus_addr = 4'h7; bus_rd = 1'b0;
      #1;
      check(bus_rdata === 8'h00, "R12 rdata zero without strobe", 48'(bus_rdata), 48'h0);

      // R1 data ports drive lines
      wr(4'h0, 8'hA5); wr(4'h1, 8'h5A); wr(4'h2, 8'hC3);
      wr(4'h3, 8'h3C); wr(4'h4, 8'h0F); wr(4'h5, 8'hF0);
      #1;
      check(pad_drive === 48'hF00F3CC35AA5, "R1 six port pattern", pad_drive, 48'hF00F3CC35AA5);
      wr(4'h2, 8'h00);
      #1;
      check(pad_drive === 48'hF00F3C005AA5, "R1 release port2", pad_drive, 48'hF00F3C005AA5);

      // R11 read-only offset
      wr(4'h6, 8'hFF);
      rd_chk(4'h6, 8'h00, "R11 offset 6 reads zero");
      check(pad_drive === 48'hF00F3C005AA5, "R11 write to 6 ignored", pad_drive, 48'hF00F3C005AA5);

      // R2 synchronized input reads
      set_pads(48'h123456789ABC);
      rd_chk(4'h0, 8'h00, "R2 not visible after one edge");
      rd_chk(4'h0, 8'hBC, "R2 port0 level");
      rd_chk(4'h5, 8'h12, "R2 port5 level");
      rd_chk(4'h3, 8'h56, "R2 port3 level");
      set_pads(48'h0);
      idle(4);

      // R5 edge polarity
      wr(4'h7, 8'h40); wr(4'h8, 8'h0F);
      wr(4'h7, 8'h80); wr(4'h8, 8'hFF);
      wr(4'h7, 8'hC0);
      set_pads(48'h0000000000FF);
      idle(4);
      rd_chk(4'h8, 8'h0F, "R5 rising edges on pol=1 lines");
      check(irq === 1'b1, "R9 irq raised", 48'(irq), 48'h1);
      set_pads(48'h0);
      idle(4);
      rd_chk(4'h8, 8'hFF, "R5 falling edges on pol=0 lines");

      // R6 masked port1
      set_pads(48'h00000000FF00);
      idle(4);
      set_pads(48'h0);
      idle(4);
      rd_chk(4'h9, 8'h00, "R6 masked lines stay clear");
      wr(4'h7, 8'h80); wr(4'h9, 8'hFF); wr(4'h7, 8'hC0);
      idle(3);
      rd_chk(4'h9, 8'h00, "R6 late enable brings no old edge");

      // R7 / R9 partial and full clear
      wr(4'h8, 8'h0F);
      rd_chk(4'h8, 8'hF0, "R7 partial clear");
      check(irq === 1'b1, "R9 irq held while bits remain", 48'(irq), 48'h1);
      wr(4'h8, 8'hF0);
      rd_chk(4'h8, 8'h00, "R7 full clear");
      check(irq === 1'b0, "R9 irq drops after last clear", 48'(irq), 48'h0);

      // R10 upper ports never interrupt
      set_pads(48'hFFFFFF000000);
      idle(4);
      check(irq === 1'b0, "R10 upper rise no irq", 48'(irq), 48'h0);
      set_pads(48'h0);
      idle(4);
      check(irq === 1'b0, "R10 upper fall no irq", 48'(irq), 48'h0);

      // R8 edge and clear on the same edge
      wr(4'h7, 8'h40); wr(4'hA, 8'h01);
      wr(4'h7, 8'h80); wr(4'hA, 8'h01);
      wr(4'h7, 8'hC0);
      set_pads(48'h000000010000);
      @(negedge clk);
      wr(4'hA, 8'h01);
      rd_chk(4'hA, 8'h01, "R8 edge wins over clear");
      wr(4'hA, 8'h01);
      rd_chk(4'hA, 8'h00, "R7 clear after collision");

      idle(2);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule